// File: doc/BRIEF.md
# Serial Channel Mode and Command Register File

This block is the control register file for one channel of a dual asynchronous serial controller. Two mode bytes sit behind a single bus address. An internal pointer selects between them: the first access after reset or after a pointer-reset command reaches the first mode byte, and every later access reaches the second. The block decodes a write-only command byte and drives enable, reset, break and format controls to the serial engines. It also assembles a read-only status byte from flags supplied by the receive FIFO and the transmitter.

The bus is a simple single-cycle register port: one write or one read strobe, a small address and an 8-bit data path. Read data is combinational from the address. Every register update and every command pulse appears after the clock edge that samples the write. The character format, the channel loop mode and the stop length are decoded continuously from the stored mode bytes.

Top module: `uart_chan_ctrl`

## Requirements
- R1: Address 0 is the mode address, and both reads and writes to it count as accesses. The first access after reset, or after command code 001, uses mode byte 1. Every later access uses mode byte 2 until the next code 001. A read returns the byte the pointer selects before the access advances it.
- R2: `par_mode_o` equals mode byte 1 bits [4:3] (00 parity, 01 forced, 10 none, 11 multi-drop). `par_odd_o` equals bit 2. `char_len_o` equals bits [1:0], which is the character length minus 5.
- R3: `chan_mode_o` equals mode byte 2 bits [7:6] (00 normal, 01 echo, 10 local loop, 11 remote loop). `tx_rts_ctl_o` equals bit 5 and `tx_cts_en_o` equals bit 4.
- R4: `stop_len_o` gives the stop length in sixteenths of a bit: 16*k + 8 + n, plus 8 more when k is 0 and `char_len_o` is 00. Here k is mode byte 2 bit 3 and n is bits [2:0].
- R5: A write to the command address (2) with bits [6:4] equal to 010, 011 or 101 pulses `rx_rst_o`, `tx_rst_o` or `brk_chg_clr_o` high for exactly the cycle after the write.
- R6: Command code 110 sets `brk_o` and code 111 clears it. Other codes leave it unchanged.
- R7: In a command write, bit 0 enables rx, bit 1 disables rx, bit 2 enables tx and bit 3 disables tx. When both bits of a pair are set, the disable wins. These bits act in the same write as the encoded command in bits [6:4].
- R8: Reading the status address (1) returns, from bit 7 down to bit 0: break, framing error, parity error, overrun, tx empty, tx ready, FIFO full, rx ready. All bits are live inputs except overrun.
- R9: Overrun is sticky. A pulse on `rx_ovr_i` sets it, and only command code 100 clears it. A set in the same cycle as a clear wins.
- R10: After reset the pointer selects mode byte 1, both mode bytes are zero, both directions are disabled, and break, overrun and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rx_brk_i | input | 1 | Break flag of the top FIFO character |
| rx_fe_i | input | 1 | Framing error of the top FIFO character |
| rx_pe_i | input | 1 | Parity error of the top FIFO character |
| rx_ovr_i | input | 1 | Overrun event pulse |
| tx_empty_i | input | 1 | Transmitter empty |
| tx_ready_i | input | 1 | Transmit holding register ready |
| fifo_full_i | input | 1 | Receive FIFO full |
| rx_ready_i | input | 1 | Receive data available |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_rst_o | output | 1 | Receiver reset pulse |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| brk_chg_clr_o | output | 1 | Break-change interrupt clear pulse |
| brk_o | output | 1 | Send break |
| par_mode_o | output | 2 | Parity handling |
| par_odd_o | output | 1 | Odd parity select |
| char_len_o | output | 2 | Character length minus 5 |
| chan_mode_o | output | 2 | Channel loop mode |
| tx_rts_ctl_o | output | 1 | Transmitter RTS control enable |
| tx_cts_en_o | output | 1 | Transmitter CTS gating enable |
| stop_len_o | output | 5 | Stop length in sixteenths of a bit |

## Verification
The assertions assume that a write and a read never occur in the same cycle, and that the flag and strobe inputs are settled at each rising edge. The bench drives every input just after a rising edge, and only one of `wr_i` or `rd_i` is ever high in a cycle. This holds in the directed sequences and in the random phase. With that rule in force, the pointer advance and the command effects each have only one cause per cycle, which is what the pointer and enable properties rely on.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_PTR_RST = 3'b001,
    CMD_RX_RST  = 3'b010,
    CMD_TX_RST  = 3'b011,
    CMD_ERR_RST = 3'b100,
    CMD_BCH_RST = 3'b101,
    CMD_BRK_ON  = 3'b110,
    CMD_BRK_OFF = 3'b111
  } cmd_e;
endpackage

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_rst_i,
  output logic          sel2_o,
  output logic [DW-1:0] mr1_o,
  output logic [DW-1:0] mr2_o
);
  logic          ptr_q;
  logic [DW-1:0] mr1_q, mr2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
      mr1_q <= '0;
      mr2_q <= '0;
    end else begin
      if (ptr_rst_i)  ptr_q <= 1'b0;
      else if (acc_i) ptr_q <= 1'b1;
      if (acc_i && we_i) begin
        if (ptr_q) mr2_q <= wdata_i;
        else       mr1_q <= wdata_i;
      end
    end
  end

  assign sel2_o = ptr_q;
  assign mr1_o  = mr1_q;
  assign mr2_o  = mr2_q;

  AST_PTR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q && !ptr_rst_i |=> ptr_q); // R1
  AST_MR1_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q |=> $stable(mr1_q)); // R1
endmodule

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [6:0] cmd_i,
  output logic       ptr_rst_o,
  output logic       err_rst_o,
  output logic [1:0] en_o,      // [0] rx, [1] tx
  output logic       rx_rst_o,
  output logic       tx_rst_o,
  output logic       bch_clr_o,
  output logic       brk_o
);
  cmd_e code;
  logic rx_rst_q, tx_rst_q, bch_q, brk_q;

  assign code      = cmd_e'(cmd_i[6:4]);
  assign ptr_rst_o = we_i && (code == CMD_PTR_RST);
  assign err_rst_o = we_i && (code == CMD_ERR_RST);

  // one enable/disable pair per direction; disable wins
  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  en_q <= 1'b0;
      else if (we_i && cmd_i[2*d+1]) en_q <= 1'b0;
      else if (we_i && cmd_i[2*d])   en_q <= 1'b1;
    end
    assign en_o[d] = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
      bch_q    <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      rx_rst_q <= we_i && (code == CMD_RX_RST);
      tx_rst_q <= we_i && (code == CMD_TX_RST);
      bch_q    <= we_i && (code == CMD_BCH_RST);
      if (we_i && code == CMD_BRK_ON)       brk_q <= 1'b1;
      else if (we_i && code == CMD_BRK_OFF) brk_q <= 1'b0;
    end
  end

  assign rx_rst_o  = rx_rst_q;
  assign tx_rst_o  = tx_rst_q;
  assign bch_clr_o = bch_q;
  assign brk_o     = brk_q;

  AST_RX_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cmd_i[1] |=> !en_o[0]); // R7
  AST_TX_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cmd_i[3] |=> !en_o[1]); // R7
  AST_BRK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cmd_i[6:4] == 3'b110 |=> brk_o); // R6
  AST_BRK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cmd_i[6:4] == 3'b111 |=> !brk_o); // R6
endmodule

// File: rtl/uart_stat.sv
module uart_stat
  import uart_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovr_set_i,
  input  logic          ovr_clr_i,
  input  logic          brk_i,
  input  logic          fe_i,
  input  logic          pe_i,
  input  logic          tx_empty_i,
  input  logic          tx_ready_i,
  input  logic          full_i,
  input  logic          rx_ready_i,
  output logic [DW-1:0] stat_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_set_i) ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign stat_o = {brk_i, fe_i, pe_i, ovr_q, tx_empty_i, tx_ready_i, full_i, rx_ready_i};

  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !ovr_clr_i |=> ovr_q); // R9
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> ovr_q); // R9
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_ctl_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned MODE_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned CMD_ADDR  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_brk_i,
  input  logic          rx_fe_i,
  input  logic          rx_pe_i,
  input  logic          rx_ovr_i,
  input  logic          tx_empty_i,
  input  logic          tx_ready_i,
  input  logic          fifo_full_i,
  input  logic          rx_ready_i,
  output logic          rx_en_o,
  output logic          tx_en_o,
  output logic          rx_rst_o,
  output logic          tx_rst_o,
  output logic          brk_chg_clr_o,
  output logic          brk_o,
  output logic [1:0]    par_mode_o,
  output logic          par_odd_o,
  output logic [1:0]    char_len_o,
  output logic [1:0]    chan_mode_o,
  output logic          tx_rts_ctl_o,
  output logic          tx_cts_en_o,
  output logic [4:0]    stop_len_o
);
  localparam logic [AW-1:0] A_MODE = AW'(MODE_ADDR);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
  localparam logic [AW-1:0] A_CMD  = AW'(CMD_ADDR);
  localparam int unsigned   SW     = 5;

  logic          mode_acc, cmd_we, ptr_rst, err_rst, sel2;
  logic [DW-1:0] mr1, mr2, stat;
  logic [1:0]    en;

  assign mode_acc = (wr_i || rd_i) && (addr_i == A_MODE);
  assign cmd_we   = wr_i && (addr_i == A_CMD);

  uart_mode_regs u_mode (
    .clk_i, .rst_ni,
    .acc_i     (mode_acc),
    .we_i      (wr_i),
    .wdata_i,
    .ptr_rst_i (ptr_rst),
    .sel2_o    (sel2),
    .mr1_o     (mr1),
    .mr2_o     (mr2)
  );

  uart_cmd_dec u_cmd (
    .clk_i, .rst_ni,
    .we_i      (cmd_we),
    .cmd_i     (wdata_i[6:0]),
    .ptr_rst_o (ptr_rst),
    .err_rst_o (err_rst),
    .en_o      (en),
    .rx_rst_o,
    .tx_rst_o,
    .bch_clr_o (brk_chg_clr_o),
    .brk_o
  );

  uart_stat u_stat (
    .clk_i, .rst_ni,
    .ovr_set_i  (rx_ovr_i),
    .ovr_clr_i  (err_rst),
    .brk_i      (rx_brk_i),
    .fe_i       (rx_fe_i),
    .pe_i       (rx_pe_i),
    .tx_empty_i,
    .tx_ready_i,
    .full_i     (fifo_full_i),
    .rx_ready_i,
    .stat_o     (stat)
  );

  always_comb begin
    if (addr_i == A_MODE)      rdata_o = sel2 ? mr2 : mr1;
    else if (addr_i == A_STAT) rdata_o = stat;
    else                       rdata_o = '0;
  end

  assign rx_en_o      = en[0];
  assign tx_en_o      = en[1];
  assign par_mode_o   = mr1[4:3];
  assign par_odd_o    = mr1[2];
  assign char_len_o   = mr1[1:0];
  assign chan_mode_o  = mr2[7:6];
  assign tx_rts_ctl_o = mr2[5];
  assign tx_cts_en_o  = mr2[4];

  // stop length in 1/16 bit: whole bit from k, half bit, n/16, extra half for short chars
  logic         stop_k;
  logic [SW-1:0] stop_extra;
  assign stop_k     = mr2[3];
  assign stop_extra = (!stop_k && mr1[1:0] == 2'b00) ? SW'(8) : SW'(0);
  assign stop_len_o = {stop_k, 4'b0000} + SW'(8) + {2'b00, mr2[2:0]} + stop_extra;

  AST_STOP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_len_o >= 5'd8); // R4
endmodule

// File: tb/uart_chan_ctrl_bench.sv
module uart_chan_ctrl_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic brk_i = 0, fe_i = 0, pe_i = 0, ovr_i = 0, temp_i = 0, trdy_i = 0, full_i = 0, rrdy_i = 0;
  logic rx_en, tx_en, rx_rst, tx_rst, bclr, brk;
  logic [1:0] pmode, clen, cmode;
  logic podd, rts, cts;
  logic [4:0] stop;

  int n_tests = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_chan_ctrl u_uart_chan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .rx_brk_i(brk_i), .rx_fe_i(fe_i), .rx_pe_i(pe_i), .rx_ovr_i(ovr_i),
    .tx_empty_i(temp_i), .tx_ready_i(trdy_i), .fifo_full_i(full_i), .rx_ready_i(rrdy_i),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_rst_o(rx_rst), .tx_rst_o(tx_rst),
    .brk_chg_clr_o(bclr), .brk_o(brk), .par_mode_o(pmode), .par_odd_o(podd),
    .char_len_o(clen), .chan_mode_o(cmode), .tx_rts_ctl_o(rts), .tx_cts_en_o(cts),
    .stop_len_o(stop)
  );

  // behavioural reference
  bit m_ptr, m_rxen, m_txen, m_brk, m_ovr, m_rxr, m_txr, m_bcl;
  logic [7:0] m_mr1, m_mr2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_rxen = 0; m_txen = 0; m_brk = 0; m_ovr = 0;
      m_rxr = 0; m_txr = 0; m_bcl = 0; m_mr1 = 0; m_mr2 = 0;
    end else begin
      int code;
      code = wdata[6:4];
      m_rxr = 0; m_txr = 0; m_bcl = 0;
      if (ovr_i) m_ovr = 1;
      else if (wr && addr == 2 && code == 4) m_ovr = 0;
      if (wr && addr == 2) begin
        if (code == 1) m_ptr = 0;
        if (code == 2) m_rxr = 1;
        if (code == 3) m_txr = 1;
        if (code == 5) m_bcl = 1;
        if (code == 6) m_brk = 1;
        if (code == 7) m_brk = 0;
        if (wdata[1]) m_rxen = 0; else if (wdata[0]) m_rxen = 1;
        if (wdata[3]) m_txen = 0; else if (wdata[2]) m_txen = 1;
      end
      if ((wr || rd) && addr == 0) begin
        if (wr) begin
          if (m_ptr) m_mr2 = wdata; else m_mr1 = wdata;
        end
        m_ptr = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {brk_i, fe_i, pe_i, m_ovr, temp_i, trdy_i, full_i, rrdy_i};
  endfunction

  function automatic int exp_stop();
    int k, n, s;
    k = m_mr2[3]; n = m_mr2[2:0];
    s = 16 * k + 8 + n;
    if (k == 0 && m_mr1[1:0] == 0) s += 8;
    return s;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [7:0] er;
    er = (addr == 0) ? (m_ptr ? m_mr2 : m_mr1) : (addr == 1) ? exp_stat() : 8'h00;
    chk("R1 rdata", rdata, er);
    chk("R2 fmt", {pmode, podd, clen}, m_mr1[4:0]);
    chk("R3 chan", {cmode, rts, cts}, m_mr2[7:4]);
    chk("R4 stop", stop, exp_stop());
    chk("R5 pulses", {rx_rst, tx_rst, bclr}, {m_rxr, m_txr, m_bcl});
    chk("R6 break", brk, m_brk);
    chk("R7 enables", {rx_en, tx_en}, {m_rxen, m_txen});
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 0; addr = 3;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1; rd = 1; addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #1; rd = 0; addr = 3;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    #(PERIOD * 3); rst_n = 1; #1;
    // R10 reset state
    @(negedge clk);
    chk("R10 enables", {rx_en, tx_en, brk, rx_rst, tx_rst, bclr}, 0);
    chk("R10 mode", {pmode, podd, clen, cmode, rts, cts}, 0);
    bus_rd(1, d); chk("R10 ovr", d[4], 0);
    // R1: read then writes go through pointer
    bus_rd(0, d); chk("R1 first read mr1", d, 8'h00);
    bus_wr(0, 8'hB5);                          // second access -> mr2
    @(negedge clk); chk("R3 mr2 via ptr", {cmode, rts, cts}, 4'hB);
    chk("R1 mr1 untouched", {pmode, podd, clen}, 0);
    bus_wr(2, 8'h10);                          // reset pointer
    bus_wr(0, 8'h1E);                          // mr1
    @(negedge clk); chk("R2 mr1 fields", {pmode, podd, clen}, 5'b11110);
    chk("R4 stop k0 n5 len7", stop, 13);
    bus_rd(0, d); chk("R1 read mr2", d, 8'hB5);
    bus_rd(0, d); chk("R1 read mr2 again", d, 8'hB5);
    bus_wr(2, 8'h10);
    bus_rd(0, d); chk("R1 read mr1 after reset ptr", d, 8'h1E);
    // R4 corners
    bus_wr(2, 8'h10); bus_wr(0, 8'h00); bus_wr(0, 8'h05);
    @(negedge clk); chk("R4 stop short char", stop, 21);
    bus_wr(0, 8'h4F);
    @(negedge clk); chk("R4 stop k1", stop, 31);
    // R7 enables and priority
    bus_wr(2, 8'h05);
    @(negedge clk); chk("R7 enable both", {rx_en, tx_en}, 2'b11);
    bus_wr(2, 8'h0F);
    @(negedge clk); chk("R7 disable wins", {rx_en, tx_en}, 2'b00);
    bus_wr(2, 8'h25);                          // reset rx + enable both
    @(negedge clk); chk("R7 same write", {rx_en, tx_en}, 2'b11);
    // R5 pulse timing
    @(posedge clk); #1; wr = 1; addr = 2; wdata = 8'h30;
    @(negedge clk); chk("R5 no pulse yet", tx_rst, 0);
    @(posedge clk); #1; wr = 0; addr = 3;
    @(negedge clk); chk("R5 tx pulse", tx_rst, 1);
    @(negedge clk); chk("R5 tx pulse one cycle", tx_rst, 0);
    bus_wr(2, 8'h50);
    // R6 break
    bus_wr(2, 8'h60); @(negedge clk); chk("R6 break on", brk, 1);
    bus_wr(2, 8'h00); @(negedge clk); chk("R6 nop holds", brk, 1);
    bus_wr(2, 8'h70); @(negedge clk); chk("R6 break off", brk, 0);
    // R8 / R9 status
    @(posedge clk); #1; {brk_i, fe_i, pe_i, temp_i, trdy_i, full_i, rrdy_i} = 7'b1010101;
    ovr_i = 1;
    @(posedge clk); #1; ovr_i = 0;
    bus_rd(1, d); chk("R8 status layout", d, 8'b1011_0101);
    bus_wr(2, 8'h00);
    bus_rd(1, d); chk("R9 ovr sticky", d[4], 1);
    bus_wr(2, 8'h40);
    bus_rd(1, d); chk("R9 ovr cleared", d[4], 0);
    @(posedge clk); #1; ovr_i = 1; wr = 1; addr = 2; wdata = 8'h40;
    @(posedge clk); #1; ovr_i = 0; wr = 0; addr = 3;
    bus_rd(1, d); chk("R9 set beats clear", d, {brk_i, fe_i, pe_i, 1'b1, temp_i, trdy_i, full_i, rrdy_i});
    // random phase, compared every clock
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      case ($urandom_range(0, 2))
        0: begin wr = 1; rd = 0; end
        1: begin wr = 0; rd = 1; end
        default: begin wr = 0; rd = 0; end
      endcase
      addr  = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      ovr_i = ($urandom_range(0, 7) == 0);
      {brk_i, fe_i, pe_i, temp_i, trdy_i, full_i, rrdy_i} = 7'($urandom);
    end
    @(posedge clk); #1; wr = 0; rd = 0; ovr_i = 0;
    repeat (3) @(posedge clk);
    summary();
  end
endmodule